// File: doc/BRIEF.md
# Threshold Coring Luma Noise Reducer

This block cleans or sharpens a stream of luma samples. Each cycle it may take an original luma sample and a band-filtered copy of that same sample. It takes the magnitude of the filtered value and compares it with a programmable threshold. In noise mode, a filtered value below the threshold is taken to be noise. A fraction of it is subtracted from the original. In sharpness mode, a filtered value above the threshold is taken to be real detail. A fraction of it is added to the original. In every other case the original sample passes through unchanged.

A position tracker outside the block supplies a flag for each sample. The flag says whether the sample lies in a block border or in the block interior. It selects one of two 4-bit gain codes. The scaled correction is rounded to an integer and applied. The result is clamped to the 10-bit luma range. The datapath is a two-stage streaming pipeline, and a valid bit travels with each sample.

Top module: `luma_coring_nr`

## Requirements
- R1: `outValid` equals `inValid` delayed by exactly two clock edges. Each output sample appears on `lumaOut` on the same edge as its `outValid`.
- R2: With `sharpMode`=0 and |`filtIn`| < `threshold`, the output is `lumaIn` − round(`filtIn`·g/8), where g is the selected gain code. A zero filtered value leaves the sample unchanged.
- R3: With `sharpMode`=1 and |`filtIn`| > `threshold`, the output is `lumaIn` + round(`filtIn`·g/16), where g is the selected gain code.
- R4: When the mode's threshold condition fails, including |`filtIn`| equal to `threshold`, `lumaOut` equals `lumaIn`. In noise mode a threshold of 0 therefore always passes the sample through.
- R5: `isBorder`=1 selects `gainBorder` and `isBorder`=0 selects `gainData`. The gain that is not selected has no effect on the output.
- R6: Gain codes 9 to 15 act as code 8. This gives a maximum gain of 1 in noise mode and 0.5 in sharpness mode.
- R7: The result is saturated to 0..1023. A sum above 1023 gives 1023, and a difference below 0 gives 0.
- R8: While `rstN` is low, `outValid` is 0 and `lumaOut` is 0.
- R9: Rounding is to the nearest integer, with exact halves rounded toward +infinity. The value computed is floor((`filtIn`·w + 8)/16), where w = 2g in noise mode and w = g in sharpness mode. For example, a correction of −0.5 becomes 0 and +0.5 becomes 1.
- R10: `filtIn` is signed 11-bit two's complement. The value −1024 has magnitude 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input sample is valid this cycle |
| lumaIn | input | 10 | Original luma sample |
| filtIn | input | 11 | Band-filtered luma, signed |
| isBorder | input | 1 | 1 = border sample, 0 = interior sample |
| sharpMode | input | 1 | 0 = noise reduction, 1 = sharpening |
| threshold | input | 6 | Magnitude threshold, 0..63 |
| gainBorder | input | 4 | Gain code for border samples |
| gainData | input | 4 | Gain code for interior samples |
| outValid | output | 1 | Output sample is valid |
| lumaOut | output | 10 | Corrected luma sample |

## Verification
Every result is due two rising edges after its inputs are presented. One edge loads the first stage and the next loads the output register. The directed tasks drive inputs on a falling edge, drop `inValid` on the next falling edge, and compare on the falling edge after the second rising edge. At that point both `outValid` and `lumaOut` are settled. The streaming task drives a new sample on every falling edge. On each falling edge it checks the output against the sample driven two falling edges earlier, including cycles with valid low. This confirms that the latency does not depend on how densely samples arrive.

// File: rtl/coring_pkg.sv
package coring_pkg;
  // Strobes from control to datapath, all for the current cycle
  typedef struct packed {
    logic s1Load;   // capture a new sample into stage 1
    logic s2Load;   // capture stage-1 result into the output register
    logic apply;    // threshold condition met for the incoming sample
    logic addMode;  // 1: add correction (sharpen), 0: subtract (denoise)
  } coreStrobe_t;
endpackage

// File: rtl/coring_ctrl.sv
module coring_ctrl
  import coring_pkg::*;
#(
  parameter int FILT_W   = 11,
  parameter int THR_W    = 6,
  parameter int GAIN_W   = 4,
  parameter int GAIN_MAX = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [FILT_W-1:0] filtIn,
  input  logic                     isBorder,
  input  logic                     sharpMode,
  input  logic [THR_W-1:0]         threshold,
  input  logic [GAIN_W-1:0]        gainBorder,
  input  logic [GAIN_W-1:0]        gainData,
  output coreStrobe_t              strobe,
  output logic [GAIN_W-1:0]        gainSel,
  output logic                     outValid
);
  localparam logic [GAIN_W-1:0] GAIN_CAP = GAIN_W'(GAIN_MAX);

  logic [FILT_W-1:0] magF;
  logic [FILT_W-1:0] thrX;
  logic [GAIN_W-1:0] gainRaw;
  logic              belowThr;
  logic              aboveThr;
  logic              valid1;

  // Magnitude: negating the most negative code yields its unsigned magnitude
  always_comb begin
    magF = filtIn[FILT_W-1] ? FILT_W'(-filtIn) : FILT_W'(filtIn);
    thrX = FILT_W'(threshold);
    belowThr = magF < thrX;
    aboveThr = magF > thrX;
  end

  always_comb begin
    gainRaw = isBorder ? gainBorder : gainData;
    gainSel = (gainRaw > GAIN_CAP) ? GAIN_CAP : gainRaw;
  end

  always_comb begin
    strobe.s1Load  = inValid;
    strobe.s2Load  = valid1;
    strobe.apply   = sharpMode ? aboveThr : belowThr;
    strobe.addMode = sharpMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valid1   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      valid1   <= inValid;
      outValid <= valid1;
    end
  end
endmodule

// File: rtl/coring_dp.sv
module coring_dp
  import coring_pkg::*;
#(
  parameter int LUMA_W = 10,
  parameter int FILT_W = 11,
  parameter int GAIN_W = 4,
  parameter int FRAC_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  coreStrobe_t              strobe,
  input  logic [GAIN_W-1:0]        gainSel,
  input  logic [LUMA_W-1:0]        lumaIn,
  input  logic signed [FILT_W-1:0] filtIn,
  output logic [LUMA_W-1:0]        lumaOut
);
  localparam int W_W    = GAIN_W + 1;
  localparam int PROD_W = FILT_W + W_W + 1;
  localparam int SUM_W  = PROD_W + 2;
  localparam logic signed [PROD_W-1:0] HALF_V   = PROD_W'(1 << (FRAC_W - 1));
  localparam logic signed [SUM_W-1:0]  LUMA_TOP = SUM_W'((1 << LUMA_W) - 1);

  logic [W_W-1:0]           wNext;
  logic [LUMA_W-1:0]        lumaQ;
  logic signed [FILT_W-1:0] filtQ;
  logic [W_W-1:0]           wQ;
  logic                     applyQ;
  logic                     addQ;

  // Noise steps are twice as coarse as sharpen steps on the common scale
  always_comb begin
    wNext = strobe.addMode ? {1'b0, gainSel} : {gainSel, 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lumaQ  <= '0;
      filtQ  <= '0;
      wQ     <= '0;
      applyQ <= 1'b0;
      addQ   <= 1'b0;
    end else if (strobe.s1Load) begin
      lumaQ  <= lumaIn;
      filtQ  <= filtIn;
      wQ     <= wNext;
      applyQ <= strobe.apply;
      addQ   <= strobe.addMode;
    end
  end

  logic signed [PROD_W-1:0] filtX;
  logic signed [PROD_W-1:0] wX;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] corr;
  logic signed [SUM_W-1:0]  base;
  logic signed [SUM_W-1:0]  corrX;
  logic signed [SUM_W-1:0]  res;
  logic [LUMA_W-1:0]        satVal;

  always_comb begin
    filtX = PROD_W'(filtQ);
    wX    = PROD_W'($signed({1'b0, wQ}));
    prod  = filtX * wX;
    corr  = (prod + HALF_V) >>> FRAC_W;
    base  = SUM_W'($signed({1'b0, lumaQ}));
    corrX = SUM_W'(corr);
    if (!applyQ)   res = base;
    else if (addQ) res = base + corrX;
    else           res = base - corrX;
    if (res < 0)             satVal = '0;
    else if (res > LUMA_TOP) satVal = '1;
    else                     satVal = res[LUMA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lumaOut <= '0;
    else if (strobe.s2Load) lumaOut <= satVal;
  end
endmodule

// File: rtl/luma_coring_nr.sv
module luma_coring_nr
  import coring_pkg::*;
#(
  parameter int LUMA_W   = 10,
  parameter int FILT_W   = 11,
  parameter int THR_W    = 6,
  parameter int GAIN_W   = 4,
  parameter int GAIN_MAX = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [LUMA_W-1:0]        lumaIn,
  input  logic signed [FILT_W-1:0] filtIn,
  input  logic                     isBorder,
  input  logic                     sharpMode,
  input  logic [THR_W-1:0]         threshold,
  input  logic [GAIN_W-1:0]        gainBorder,
  input  logic [GAIN_W-1:0]        gainData,
  output logic                     outValid,
  output logic [LUMA_W-1:0]        lumaOut
);
  localparam int FRAC_W = 4;

  coreStrobe_t       strobe;
  logic [GAIN_W-1:0] gainSel;

  coring_ctrl #(
    .FILT_W(FILT_W), .THR_W(THR_W), .GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .filtIn(filtIn),
    .isBorder(isBorder), .sharpMode(sharpMode), .threshold(threshold),
    .gainBorder(gainBorder), .gainData(gainData),
    .strobe(strobe), .gainSel(gainSel), .outValid(outValid)
  );

  coring_dp #(
    .LUMA_W(LUMA_W), .FILT_W(FILT_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .gainSel(gainSel),
    .lumaIn(lumaIn), .filtIn(filtIn), .lumaOut(lumaOut)
  );
endmodule

// File: rtl/coring_chk.sv
module coring_chk #(
  parameter int LUMA_W = 10,
  parameter int FILT_W = 11,
  parameter int THR_W  = 6
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic [LUMA_W-1:0]        lumaIn,
  input logic signed [FILT_W-1:0] filtIn,
  input logic                     sharpMode,
  input logic [THR_W-1:0]         threshold,
  input logic                     outValid,
  input logic [LUMA_W-1:0]        lumaOut
);
  logic [1:0] liveCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               liveCnt <= '0;
    else if (liveCnt != 2'd3) liveCnt <= liveCnt + 2'd1;
  end

  p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rstN)
    (liveCnt >= 2'd2) |-> (outValid == $past(inValid, 2)));

  p_zero_filt_r2: assert property (@(posedge clk) disable iff (!rstN)
    (liveCnt >= 2'd2 && $past(inValid, 2) && $past(filtIn, 2) == '0)
      |-> (lumaOut == $past(lumaIn, 2)));

  p_thr_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (liveCnt >= 2'd2 && $past(inValid, 2) && !$past(sharpMode, 2) &&
     $past(threshold, 2) == '0) |-> (lumaOut == $past(lumaIn, 2)));

  p_reset_r8: assert property (@(posedge clk)
    !rstN |=> (!outValid && lumaOut == '0));
endmodule

bind luma_coring_nr coring_chk #(
  .LUMA_W(LUMA_W), .FILT_W(FILT_W), .THR_W(THR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .lumaIn(lumaIn),
  .filtIn(filtIn), .sharpMode(sharpMode), .threshold(threshold),
  .outValid(outValid), .lumaOut(lumaOut)
);

// File: tb/tb_luma_coring_nr.sv
`timescale 1ns/1ps
module tb_luma_coring_nr;
  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic [9:0]        lumaIn = '0;
  logic signed [10:0] filtIn = '0;
  logic              isBorder = 1'b0;
  logic              sharpMode = 1'b0;
  logic [5:0]        threshold = '0;
  logic [3:0]        gainBorder = '0;
  logic [3:0]        gainData = '0;
  logic              outValid;
  logic [9:0]        lumaOut;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  luma_coring_nr dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .lumaIn(lumaIn),
    .filtIn(filtIn), .isBorder(isBorder), .sharpMode(sharpMode),
    .threshold(threshold), .gainBorder(gainBorder), .gainData(gainData),
    .outValid(outValid), .lumaOut(lumaOut)
  );

  task automatic check(string req, int actual, int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // Reference from the requirements
  function automatic int refModel(int luma, int f, bit border, bit mode,
                                  int thr, int gb, int gd);
    int code = border ? gb : gd;
    int mag = (f < 0) ? -f : f;
    int w;
    int corr;
    int r;
    bit hit;
    if (code > 8) code = 8;
    hit = mode ? (mag > thr) : (mag < thr);
    w = mode ? code : 2 * code;
    corr = (f * w + 8) >>> 4;
    if (!hit) r = luma;
    else r = mode ? luma + corr : luma - corr;
    if (r < 0) r = 0;
    if (r > 1023) r = 1023;
    return r;
  endfunction

  task automatic sendOne(string req, int luma, int f, bit border, bit mode,
                         int thr, int gb, int gd, int expected);
    @(negedge clk);
    inValid = 1'b1; lumaIn = 10'(luma); filtIn = 11'(f);
    isBorder = border; sharpMode = mode; threshold = 6'(thr);
    gainBorder = 4'(gb); gainData = 4'(gd);
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    check({req, " valid"}, int'(outValid), 1);
    check(req, int'(lumaOut), expected);
  endtask

  task automatic testReset();
    check("R8 valid", int'(outValid), 0);
    check("R8 luma", int'(lumaOut), 0);
  endtask

  task automatic testNoise();
    sendOne("R2 pos", 500, 20, 0, 0, 30, 0, 4, 490);
    sendOne("R2 neg", 500, -20, 0, 0, 30, 0, 4, 510);
    sendOne("R2 zero", 500, 0, 0, 0, 30, 0, 8, 500);
  endtask

  task automatic testSharp();
    sendOne("R3 pos", 500, 40, 0, 1, 30, 0, 8, 520);
    sendOne("R3 neg", 500, -40, 0, 1, 30, 0, 8, 480);
  endtask

  task automatic testThreshold();
    sendOne("R4 noise above", 500, 40, 0, 0, 30, 8, 8, 500);
    sendOne("R4 noise equal", 500, 30, 0, 0, 30, 8, 8, 500);
    sendOne("R4 sharp equal", 500, 30, 0, 1, 30, 8, 8, 500);
    sendOne("R4 sharp below", 500, 10, 0, 1, 30, 8, 8, 500);
    sendOne("R4 thr zero", 500, 1, 0, 0, 0, 8, 8, 500);
  endtask

  task automatic testGainSelect();
    sendOne("R5 border", 500, 16, 1, 0, 63, 8, 0, 484);
    sendOne("R5 interior", 500, 16, 0, 0, 63, 8, 0, 500);
  endtask

  task automatic testClamp();
    sendOne("R6 noise", 500, 16, 0, 0, 63, 0, 15, 484);
    sendOne("R6 sharp", 500, 40, 1, 1, 0, 9, 0, 520);
  endtask

  task automatic testSaturate();
    sendOne("R7 high", 1020, 1000, 0, 1, 0, 0, 8, 1023);
    sendOne("R7 low", 5, 60, 0, 0, 63, 0, 8, 0);
  endtask

  task automatic testRounding();
    sendOne("R9 half up", 500, 4, 0, 0, 63, 0, 1, 499);
    sendOne("R9 neg half", 500, -4, 0, 0, 63, 0, 1, 500);
    sendOne("R9 below half", 500, 3, 0, 0, 63, 0, 1, 500);
    sendOne("R9 sharp half", 500, 1000, 0, 1, 0, 0, 1, 563);
  endtask

  task automatic testMinFilt();
    sendOne("R10 min", 600, -1024, 0, 1, 63, 0, 8, 88);
    sendOne("R10 min ovr", 1000, -1024, 0, 1, 63, 0, 1, 936);
  endtask

  task automatic testStream();
    int   lumaH[16];
    int   filtH[16];
    bit   validH[16];
    bit   modeH[16];
    bit   borderH[16];
    int   thrH[16];
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        check("R1 stream valid", int'(outValid), int'(validH[k-2]));
        if (validH[k-2])
          check("R1 stream data", int'(lumaOut),
                refModel(lumaH[k-2], filtH[k-2], borderH[k-2], modeH[k-2],
                         thrH[k-2], 5, 3));
      end
      validH[k]  = (k % 3) != 2;
      lumaH[k]   = 100 + 50 * k;
      filtH[k]   = (k % 2 == 0) ? 7 * k - 40 : 45 - 3 * k;
      modeH[k]   = (k % 4) >= 2;
      borderH[k] = (k % 5) == 0;
      thrH[k]    = 20;
      inValid = validH[k]; lumaIn = 10'(lumaH[k]); filtIn = 11'(filtH[k]);
      sharpMode = modeH[k]; isBorder = borderH[k]; threshold = 6'(thrH[k]);
      gainBorder = 4'd5; gainData = 4'd3;
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testNoise();
    testSharp();
    testThreshold();
    testGainSelect();
    testClamp();
    testSaturate();
    testRounding();
    testMinFilt();
    testStream();
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule